// File: doc/BRIEF.md
# USB Bulk OUT Endpoint to Bus-Write DMA with Short-Packet Lock

This block sits between a USB bulk OUT endpoint and a simple bus write port. Bytes of each OUT packet are written into an endpoint FIFO. A DMA engine then drains the FIFO to the bus, one byte per write handshake, at an address that either stays fixed or steps by one. Software arms the engine with a start address, a byte count and two mode bits. The count may be far larger than any real transfer, because the end of a transfer is taken from the packet stream itself. A packet shorter than the maximum packet size ends the transfer, and a zero-length packet counts as short.

A short packet sets a sticky lock. While the lock is set, every later OUT packet is refused with NAK and its bytes are thrown away. A done interrupt is raised only once the bytes of that final packet have left the FIFO through completed bus writes. Software then aborts the engine, which flushes any leftover bytes and zeroes the count. It clears the done flag and the lock, and re-arms the engine for the next transfer. If the programmed count runs out before a short packet arrives, the engine stops and raises a separate count-done flag. Any bytes still in the FIFO stay there for a later start.

Register map. Each register is selected by `reg_idx`:
- 0 is the bus address. It reads back the live address.
- 1 is the byte count. It reads back the bytes still to go.
- 2 is the mode register: bit 0 holds the address constant, bit 1 turns on automatic start.
- 3 is the command register, write only: bit 0 starts the engine, bit 1 aborts it.
- 4 is the status register. Bit 0 is the NAK lock, bit 1 is short done and bit 2 is count done; writing 1 to any of these clears it. Bit 3 is busy and is read only.

Writes to registers 0 and 1 take effect only while the engine is idle.

Top module: `usb_out_dma`

## Requirements
- R1: After reset `bus_req`, `resp_valid`, `irq_short` and `irq_cnt` are 0. Status (index 4) and count (index 1) both read 0.
- R2: An armed engine issues no bus write while the FIFO is empty, even with a large count. Status bit 3 (busy) reads 1 while it waits.
- R3: In automatic-start mode (mode bit 1 = 1), bytes reach the bus in arrival order as soon as they are in the FIFO. Each completed write lowers the count by one.
- R4: With mode bit 0 = 1, every write uses the programmed address, which may be odd. With mode bit 0 = 0, the address rises by one per byte from the programmed value.
- R5: With mode bit 1 = 0, a start command is ignored while the FIFO is empty. A start command given while bytes are present begins draining them.
- R6: An OUT packet that begins while fewer than MAX_PKT FIFO entries are free gets NAK, and none of its bytes are ever written to the bus.
- R7: An accepted packet of fewer than MAX_PKT bytes, including zero bytes, gets ACK and sets status bit 0 (lock). While the lock is set, every OUT packet gets NAK and its bytes are discarded.
- R8: `irq_short` (status bit 1) rises only after the last byte of the short packet has been written. After a zero-length packet it rises once the FIFO has drained.
- R9: Writing 1 to status bits 0 to 2 clears them. Once the lock is cleared, a new packet gets ACK again.
- R10: Abort lets a write already requested finish, then issues no more writes. It discards the FIFO contents, and leaves the engine idle with the count reading 0.
- R11: When the count reaches zero, the engine stops and `irq_cnt` (status bit 2) is set. Bytes left in the FIFO are kept and drained after a new start.
- R12: `resp_valid` pulses in the cycle after `out_end`. `resp_ack` is 1 for an accepted packet and 0 for a refused one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, combinational on `reg_idx` |
| out_tok | input | 1 | Start of an OUT packet |
| out_valid | input | 1 | Packet data byte valid |
| out_data | input | 8 | Packet data byte |
| out_end | input | 1 | End of the OUT packet |
| resp_valid | output | 1 | Handshake response valid |
| resp_ack | output | 1 | 1 = ACK, 0 = NAK |
| bus_req | output | 1 | Bus write request, held until `bus_rdy` |
| bus_addr | output | ADDR_W | Bus write address |
| bus_data | output | 8 | Bus write data byte |
| bus_rdy | input | 1 | Bus accepts the write in this cycle |
| irq_short | output | 1 | Short-packet transfer drained to the bus |
| irq_cnt | output | 1 | Programmed count exhausted |

## Verification
The bench builds the block with MAX_PKT = 4, FIFO_DEPTH = 8, ADDR_W = 16 and CNT_W = 12. With these values two full packets fill the FIFO, so a third packet meets the no-room NAK within a few cycles. A short packet can also land while the bus is stalled, which separates its arrival from the done interrupt. A 12-bit count lets the bench use both a count that never runs out and one smaller than a packet, which brings count exhaustion with bytes left in the FIFO within reach. The random phase mixes a random bus ready, a random start address and address mode, NAK retries and a random final short length, and compares every write against the expected stream.

// File: rtl/oud_pkg.sv
package oud_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   typedef enum logic [1:0] {
      ENG_IDLE  = 2'd0,
      ENG_RUN   = 2'd1,
      ENG_FLUSH = 2'd2
   } eng_state_t;

   localparam logic [2:0] RI_ADDR  = 3'd0;
   localparam logic [2:0] RI_COUNT = 3'd1;
   localparam logic [2:0] RI_MODE  = 3'd2;
   localparam logic [2:0] RI_CMD   = 3'd3;
   localparam logic [2:0] RI_STAT  = 3'd4;

   localparam int MODE_HOLD  = 0;
   localparam int MODE_AUTO  = 1;
   localparam int CMD_GO     = 0;
   localparam int CMD_ABORT  = 1;
   localparam int ST_LOCK    = 0;
   localparam int ST_SHORT   = 1;
   localparam int ST_CNT     = 2;
   localparam int ST_BUSY    = 3;
endpackage

// File: rtl/oud_fifo.sv
module oud_fifo #(
   parameter int DEPTH = 1024,
   parameter int DW    = 8,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   input  logic          flush,
   output logic [DW-1:0] rd_data,
   output logic [CW-1:0] level
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

   generate
      if (DEPTH < 2 || (1 << PW) != DEPTH) begin : g_bad_depth
         $error("oud_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [PW:0]   wp, rp;

   assign level   = wp - rp;
   assign rd_data = mem[rp[PW-1:0]];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wp[PW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (wr_en) wp <= wp + 1'b1;
         if (flush)      rp <= wr_en ? wp + 1'b1 : wp;
         else if (rd_en) rp <= rp + 1'b1;
      end
   end

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> level < FULL_LVL);

   // R10
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> level != '0);
endmodule

// File: rtl/oud_rx.sv
module oud_rx #(
   parameter int MAX_PKT = 512,
   parameter int DEPTH   = 1024,
   localparam int LW     = $clog2(MAX_PKT + 1),
   localparam int CW     = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          out_tok,
   input  logic          out_valid,
   input  logic [7:0]    out_data,
   input  logic          out_end,
   input  logic [CW-1:0] level,
   input  logic          lock_clr,
   input  logic          flush,
   output logic          fifo_wr,
   output logic [7:0]    fifo_wdata,
   output logic          resp_valid,
   output logic          resp_ack,
   output logic          nak_lock,
   output logic          short_done
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam logic [CW-1:0] ROOM_LIM = CW'(DEPTH - MAX_PKT);
   localparam logic [LW-1:0] PKT_LIM  = LW'(MAX_PKT);

   logic          active, acc, short_pend;
   logic [LW-1:0] len;
   logic          room;

   assign room       = level <= ROOM_LIM;
   assign fifo_wr    = active && acc && out_valid && !out_end && (len < PKT_LIM);
   assign fifo_wdata = out_data;
   assign short_done = short_pend && (level == '0) && !flush;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active     <= 1'b0;
         acc        <= 1'b0;
         len        <= '0;
         resp_valid <= 1'b0;
         resp_ack   <= 1'b0;
         nak_lock   <= 1'b0;
         short_pend <= 1'b0;
      end else begin
         resp_valid <= 1'b0;
         if (lock_clr) nak_lock <= 1'b0;
         if (short_done || flush) short_pend <= 1'b0;
         if (out_tok) begin
            active <= 1'b1;
            acc    <= !nak_lock && room;
            len    <= '0;
         end else if (active) begin
            if (fifo_wr) len <= len + 1'b1;
            if (out_end) begin
               active     <= 1'b0;
               resp_valid <= 1'b1;
               resp_ack   <= acc;
               if (acc && len < PKT_LIM) begin
                  nak_lock   <= 1'b1;
                  short_pend <= 1'b1;
               end
            end
         end
      end
   end

   // R7
   locked_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nak_lock |-> !fifo_wr);

   // R12
   resp_follows_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && out_end && !out_tok) |=> resp_valid);
endmodule

// File: rtl/oud_dma.sv
module oud_dma
   import oud_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 24,
   parameter int DEPTH  = 1024,
   localparam int CW    = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              abort,
   input  logic              auto_arm,
   input  logic              hold_addr,
   input  logic              ld_addr,
   input  logic              ld_cnt,
   input  logic [ADDR_W-1:0] new_addr,
   input  logic [CNT_W-1:0]  new_cnt,
   input  logic [CW-1:0]     level,
   input  logic              bus_rdy,
   output logic              bus_req,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              fifo_pop,
   output logic              fifo_flush,
   output logic              busy,
   output logic [CNT_W-1:0]  cur_cnt,
   output logic              cnt_done
);
   timeunit 1ns;
   timeprecision 100ps;

   eng_state_t        state;
   logic              req_q, abort_pend, beat, empty, stop_req;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  cnt_q;

   assign empty      = level == '0;
   assign beat       = req_q && bus_rdy;
   assign stop_req   = abort || abort_pend;
   assign fifo_pop   = beat;
   assign fifo_flush = state == ENG_FLUSH;
   assign bus_req    = req_q;
   assign bus_addr   = addr_q;
   assign busy       = state != ENG_IDLE;
   assign cur_cnt    = cnt_q;
   assign cnt_done   = beat && cnt_q == CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ENG_IDLE;
         req_q      <= 1'b0;
         abort_pend <= 1'b0;
         addr_q     <= '0;
         cnt_q      <= '0;
      end else begin
         if (abort) abort_pend <= 1'b1;
         unique case (state)
            ENG_IDLE: begin
               if (ld_addr) addr_q <= new_addr;
               if (ld_cnt)  cnt_q  <= new_cnt;
               if (stop_req)
                  state <= ENG_FLUSH;
               else if (go && cnt_q != '0 && (auto_arm || !empty))
                  state <= ENG_RUN;
            end
            ENG_RUN: begin
               if (beat) begin
                  addr_q <= hold_addr ? addr_q : addr_q + ADDR_W'(1);
                  cnt_q  <= cnt_q - CNT_W'(1);
                  if (cnt_q == CNT_W'(1)) begin
                     state <= ENG_IDLE;
                     req_q <= 1'b0;
                  end else if (stop_req) begin
                     state <= ENG_FLUSH;
                     req_q <= 1'b0;
                  end else begin
                     req_q <= level > CW'(1);
                  end
               end else if (!req_q) begin
                  if (stop_req)   state <= ENG_FLUSH;
                  else if (!empty) req_q <= 1'b1;
               end
            end
            ENG_FLUSH: begin
               cnt_q      <= '0;
               abort_pend <= 1'b0;
               req_q      <= 1'b0;
               state      <= ENG_IDLE;
            end
            default: state <= ENG_IDLE;
         endcase
      end
   end

   // R2
   idle_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !bus_req);

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_addr)));

   // R11
   run_cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ENG_RUN) |-> cnt_q != '0);

   // R4
   hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && hold_addr) |=> $stable(bus_addr));
endmodule

// File: rtl/oud_csr.sv
module oud_csr
   import oud_pkg::*;
#(
   parameter int REG_W  = 32,
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_idx,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [CNT_W-1:0]  cur_cnt,
   input  logic              busy,
   input  logic              nak_lock,
   input  logic              short_done,
   input  logic              cnt_done,
   output logic              ld_addr,
   output logic              ld_cnt,
   output logic [ADDR_W-1:0] new_addr,
   output logic [CNT_W-1:0]  new_cnt,
   output logic              go,
   output logic              abort,
   output logic              hold_addr,
   output logic              auto_arm,
   output logic              lock_clr,
   output logic              irq_short,
   output logic              irq_cnt
);
   timeunit 1ns;
   timeprecision 100ps;

   logic stat_wr;

   assign ld_addr  = reg_we && reg_idx == RI_ADDR;
   assign ld_cnt   = reg_we && reg_idx == RI_COUNT;
   assign new_addr = reg_wdata[ADDR_W-1:0];
   assign new_cnt  = reg_wdata[CNT_W-1:0];
   assign go       = reg_we && reg_idx == RI_CMD && reg_wdata[CMD_GO];
   assign abort    = reg_we && reg_idx == RI_CMD && reg_wdata[CMD_ABORT];
   assign stat_wr  = reg_we && reg_idx == RI_STAT;
   assign lock_clr = stat_wr && reg_wdata[ST_LOCK];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_addr <= 1'b0;
         auto_arm  <= 1'b0;
         irq_short <= 1'b0;
         irq_cnt   <= 1'b0;
      end else begin
         if (reg_we && reg_idx == RI_MODE) begin
            hold_addr <= reg_wdata[MODE_HOLD];
            auto_arm  <= reg_wdata[MODE_AUTO];
         end
         irq_short <= (irq_short && !(stat_wr && reg_wdata[ST_SHORT])) || short_done;
         irq_cnt   <= (irq_cnt && !(stat_wr && reg_wdata[ST_CNT])) || cnt_done;
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_idx)
         RI_ADDR:  reg_rdata = REG_W'(cur_addr);
         RI_COUNT: reg_rdata = REG_W'(cur_cnt);
         RI_MODE: begin
            reg_rdata[MODE_HOLD] = hold_addr;
            reg_rdata[MODE_AUTO] = auto_arm;
         end
         RI_STAT: begin
            reg_rdata[ST_LOCK]  = nak_lock;
            reg_rdata[ST_SHORT] = irq_short;
            reg_rdata[ST_CNT]   = irq_cnt;
            reg_rdata[ST_BUSY]  = busy;
         end
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/usb_out_dma.sv
module usb_out_dma
   import oud_pkg::*;
#(
   parameter int REG_W      = 32,
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 24,
   parameter int MAX_PKT    = 512,
   parameter int FIFO_DEPTH = 1024,
   localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_idx,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              out_tok,
   input  logic              out_valid,
   input  logic [7:0]        out_data,
   input  logic              out_end,
   output logic              resp_valid,
   output logic              resp_ack,
   output logic              bus_req,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [7:0]        bus_data,
   input  logic              bus_rdy,
   output logic              irq_short,
   output logic              irq_cnt
);
   timeunit 1ns;
   timeprecision 100ps;

   generate
      if (FIFO_DEPTH < MAX_PKT) begin : g_bad_fifo
         $error("usb_out_dma: FIFO_DEPTH must hold at least one full packet");
      end
      if (ADDR_W > REG_W || CNT_W > REG_W) begin : g_bad_width
         $error("usb_out_dma: address and count must fit a register");
      end
      if (MAX_PKT < 1) begin : g_bad_pkt
         $error("usb_out_dma: MAX_PKT must be positive");
      end
   endgenerate

   logic [LVL_W-1:0]  level;
   logic              fifo_wr, fifo_pop, fifo_flush;
   logic [7:0]        fifo_wdata;
   logic              nak_lock, short_done, lock_clr;
   logic              ld_addr, ld_cnt, go, abort, hold_addr, auto_arm;
   logic [ADDR_W-1:0] new_addr;
   logic [CNT_W-1:0]  new_cnt, cur_cnt;
   logic              busy, cnt_done;

   oud_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .wr_en(fifo_wr), .wr_data(fifo_wdata),
      .rd_en(fifo_pop), .flush(fifo_flush),
      .rd_data(bus_data), .level(level)
   );

   oud_rx #(.MAX_PKT(MAX_PKT), .DEPTH(FIFO_DEPTH)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .out_tok(out_tok), .out_valid(out_valid), .out_data(out_data), .out_end(out_end),
      .level(level), .lock_clr(lock_clr), .flush(fifo_flush),
      .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
      .resp_valid(resp_valid), .resp_ack(resp_ack),
      .nak_lock(nak_lock), .short_done(short_done)
   );

   oud_dma #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)) u_dma (
      .clk(clk), .rst_n(rst_n),
      .go(go), .abort(abort), .auto_arm(auto_arm), .hold_addr(hold_addr),
      .ld_addr(ld_addr), .ld_cnt(ld_cnt), .new_addr(new_addr), .new_cnt(new_cnt),
      .level(level), .bus_rdy(bus_rdy),
      .bus_req(bus_req), .bus_addr(bus_addr),
      .fifo_pop(fifo_pop), .fifo_flush(fifo_flush),
      .busy(busy), .cur_cnt(cur_cnt), .cnt_done(cnt_done)
   );

   oud_csr #(.REG_W(REG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_csr (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cur_addr(bus_addr), .cur_cnt(cur_cnt), .busy(busy),
      .nak_lock(nak_lock), .short_done(short_done), .cnt_done(cnt_done),
      .ld_addr(ld_addr), .ld_cnt(ld_cnt), .new_addr(new_addr), .new_cnt(new_cnt),
      .go(go), .abort(abort), .hold_addr(hold_addr), .auto_arm(auto_arm),
      .lock_clr(lock_clr), .irq_short(irq_short), .irq_cnt(irq_cnt)
   );

   // R8
   short_irq_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_short) |-> (!bus_req && level == '0));

   // R11
   cnt_irq_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_cnt) |-> (!bus_req && cur_cnt == '0));

   // R7
   lock_refuses_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_tok && nak_lock && !lock_clr) |=> !fifo_wr);
endmodule

// File: tb/sim_usb_out_dma.sv
module sim_usb_out_dma;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int MP = 4;
   localparam int FD = 8;
   localparam int AW = 16;
   localparam int CW = 12;
   localparam int RW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [2:0]    reg_idx = '0;
   logic [RW-1:0] reg_wdata = '0;
   logic [RW-1:0] reg_rdata;
   logic          out_tok = 1'b0, out_valid = 1'b0, out_end = 1'b0;
   logic [7:0]    out_data = '0;
   logic          resp_valid, resp_ack, bus_req, bus_rdy, irq_short, irq_cnt;
   logic [AW-1:0] bus_addr;
   logic [7:0]    bus_data;

   always #2.5 clk = ~clk;

   usb_out_dma #(.REG_W(RW), .ADDR_W(AW), .CNT_W(CW), .MAX_PKT(MP), .FIFO_DEPTH(FD)) u0 (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .out_tok(out_tok), .out_valid(out_valid), .out_data(out_data), .out_end(out_end),
      .resp_valid(resp_valid), .resp_ack(resp_ack),
      .bus_req(bus_req), .bus_addr(bus_addr), .bus_data(bus_data), .bus_rdy(bus_rdy),
      .irq_short(irq_short), .irq_cnt(irq_cnt)
   );

   int checks = 0;
   int errors = 0;
   int rdy_mode = 2;
   int cyc = 0;
   int obs_d[$], obs_a[$], exp_d[$], exp_a[$];
   int nxt_addr = 0;
   bit hold_m = 1'b0;

   function automatic int pkt_byte(int tag, int i);
      return (tag * 37 + i * 11 + 5) & 8'hFF;
   endfunction

   task automatic chk(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      case (rdy_mode)
         0: bus_rdy = 1'b0;
         1: bus_rdy = 1'($urandom_range(0, 1));
         default: bus_rdy = 1'b1;
      endcase
      if (rst_n && bus_req && bus_rdy) begin
         obs_d.push_back(int'(bus_data));
         obs_a.push_back(int'(bus_addr));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_wr(logic [2:0] idx, int val);
      @(negedge clk);
      reg_we = 1'b1; reg_idx = idx; reg_wdata = RW'(val);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(logic [2:0] idx, output int val);
      @(negedge clk);
      reg_idx = idx;
      #0.5;
      val = int'(reg_rdata);
   endtask

   task automatic set_base(int a, bit h);
      nxt_addr = a; hold_m = h;
      reg_wr(3'd0, a);
   endtask

   task automatic push_exp(int tag, int first, int n);
      for (int i = first; i < first + n; i++) begin
         exp_d.push_back(pkt_byte(tag, i));
         exp_a.push_back(nxt_addr & 16'hFFFF);
         if (!hold_m) nxt_addr++;
      end
   endtask

   task automatic send_pkt(int len, int tag, output bit ack);
      @(negedge clk);
      out_tok = 1'b1;
      @(negedge clk);
      out_tok = 1'b0;
      for (int i = 0; i < len; i++) begin
         out_valid = 1'b1; out_data = 8'(pkt_byte(tag, i));
         @(negedge clk);
      end
      out_valid = 1'b0; out_end = 1'b1;
      @(negedge clk);
      out_end = 1'b0;
      chk("R12", "resp_valid after end", resp_valid, 1);
      ack = resp_ack;
   endtask

   task automatic cmp_obs(string req);
      int n;
      chk(req, "write count", obs_d.size(), exp_d.size());
      n = obs_d.size() < exp_d.size() ? obs_d.size() : exp_d.size();
      for (int k = 0; k < n; k++) begin
         chk(req, "write data", obs_d[k], exp_d[k]);
         chk(req, "write addr", obs_a[k], exp_a[k]);
      end
      obs_d.delete(); obs_a.delete(); exp_d.delete(); exp_a.delete();
   endtask

   task automatic reset_eng();
      reg_wr(3'd3, 2);
      wait_cyc(4);
      reg_wr(3'd4, 7);
      obs_d.delete(); obs_a.delete(); exp_d.delete(); exp_a.delete();
   endtask

   initial begin
      int v;
      bit ack;
      void'($urandom(32'h5EED));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1", "bus_req", bus_req, 0);
      chk("R1", "resp_valid", resp_valid, 0);
      chk("R1", "irq_short", irq_short, 0);
      chk("R1", "irq_cnt", irq_cnt, 0);
      reg_rd(3'd4, v); chk("R1", "status", v, 0);
      reg_rd(3'd1, v); chk("R1", "count", v, 0);

      // R2 armed with large count, FIFO empty
      reg_wr(3'd2, 2);
      set_base(16'h0100, 0);
      reg_wr(3'd1, 1000);
      reg_wr(3'd3, 1);
      wait_cyc(20);
      chk("R2", "writes while empty", obs_d.size(), 0);
      reg_rd(3'd4, v); chk("R2", "busy status", v, 8);

      // R3 auto drain, random ready
      rdy_mode = 1;
      send_pkt(4, 1, ack); chk("R12", "ack full packet", ack, 1); push_exp(1, 0, 4);
      send_pkt(4, 2, ack); chk("R12", "ack second packet", ack, 1); push_exp(2, 0, 4);
      wait_cyc(40);
      cmp_obs("R3");
      reg_rd(3'd1, v); chk("R3", "count after 8", v, 992);

      // R8 short packet under stalled bus, R7 lock
      rdy_mode = 0;
      send_pkt(2, 3, ack); chk("R7", "ack short packet", ack, 1); push_exp(3, 0, 2);
      wait_cyc(10);
      chk("R8", "irq_short before drain", irq_short, 0);
      reg_rd(3'd4, v); chk("R7", "lock and busy", v, 9);
      send_pkt(3, 4, ack); chk("R7", "nak while locked", ack, 0);
      rdy_mode = 2;
      wait_cyc(20);
      chk("R8", "irq_short after drain", irq_short, 1);
      cmp_obs("R7");

      // R10 abort, R9 clear
      reg_wr(3'd3, 2);
      wait_cyc(5);
      reg_rd(3'd1, v); chk("R10", "count after abort", v, 0);
      reg_rd(3'd4, v); chk("R10", "status after abort", v, 3);
      reg_wr(3'd4, 7);
      reg_rd(3'd4, v); chk("R9", "status after clear", v, 0);
      chk("R9", "irq_short cleared", irq_short, 0);
      send_pkt(4, 5, ack); chk("R9", "ack after unlock", ack, 1);
      wait_cyc(10);
      chk("R10", "no writes while idle", obs_d.size(), 0);
      reg_wr(3'd3, 2);
      wait_cyc(4);
      set_base(16'h0200, 0);
      reg_wr(3'd1, 20);
      reg_wr(3'd3, 1);
      wait_cyc(20);
      chk("R10", "flushed bytes not written", obs_d.size(), 0);

      // R10 abort during a stalled write
      rdy_mode = 0;
      send_pkt(4, 6, ack); chk("R10", "ack before abort", ack, 1);
      wait_cyc(3);
      chk("R10", "request pending", bus_req, 1);
      reg_wr(3'd3, 2);
      wait_cyc(4);
      chk("R10", "request held through abort", bus_req, 1);
      rdy_mode = 2;
      wait_cyc(10);
      push_exp(6, 0, 1);
      cmp_obs("R10");
      reg_rd(3'd4, v); chk("R10", "idle after abort", v, 0);
      reg_rd(3'd1, v); chk("R10", "count zero", v, 0);

      // R4 constant odd address
      reg_wr(3'd2, 3);
      set_base(16'h1233, 1);
      reg_wr(3'd1, 100);
      reg_wr(3'd3, 1);
      send_pkt(3, 7, ack); push_exp(7, 0, 3);
      wait_cyc(20);
      cmp_obs("R4");
      chk("R8", "irq_short hold mode", irq_short, 1);
      reset_eng();

      // R5 manual start
      reg_wr(3'd2, 0);
      set_base(16'h0300, 0);
      reg_wr(3'd1, 50);
      reg_wr(3'd3, 1);
      wait_cyc(5);
      reg_rd(3'd4, v); chk("R5", "start ignored when empty", v, 0);
      send_pkt(4, 8, ack); push_exp(8, 0, 4);
      wait_cyc(10);
      chk("R5", "no writes before start", obs_d.size(), 0);
      reg_wr(3'd3, 1);
      wait_cyc(20);
      cmp_obs("R5");
      reset_eng();

      // R6 no-room NAK
      reg_wr(3'd2, 2);
      set_base(16'h0400, 0);
      reg_wr(3'd1, 100);
      rdy_mode = 0;
      reg_wr(3'd3, 1);
      send_pkt(4, 9, ack);  chk("R6", "first ack", ack, 1);  push_exp(9, 0, 4);
      send_pkt(4, 10, ack); chk("R6", "second ack", ack, 1); push_exp(10, 0, 4);
      send_pkt(4, 11, ack); chk("R6", "nak when full", ack, 0);
      rdy_mode = 2;
      wait_cyc(30);
      cmp_obs("R6");
      reset_eng();

      // R11 count exhausted
      reg_wr(3'd2, 2);
      set_base(16'h0500, 0);
      reg_wr(3'd1, 3);
      reg_wr(3'd3, 1);
      send_pkt(4, 12, ack); push_exp(12, 0, 3);
      wait_cyc(15);
      chk("R11", "irq_cnt", irq_cnt, 1);
      reg_rd(3'd1, v); chk("R11", "count zero", v, 0);
      reg_rd(3'd4, v); chk("R11", "status", v, 4);
      cmp_obs("R11");
      reg_wr(3'd4, 4);
      reg_wr(3'd1, 5);
      reg_wr(3'd3, 1);
      wait_cyc(10);
      push_exp(12, 3, 1);
      cmp_obs("R11");
      chk("R11", "no irq_short", irq_short, 0);

      // R8 zero-length packet
      send_pkt(0, 13, ack); chk("R8", "ack zero length", ack, 1);
      wait_cyc(5);
      chk("R8", "irq_short after zlp", irq_short, 1);
      reg_rd(3'd4, v); chk("R8", "status after zlp", v, 11);
      reset_eng();

      // R3 random stream with retries
      begin
         int hb;
         int base;
         int fin;
         hb = $urandom_range(0, 1);
         base = $urandom_range(0, 16'hFFFF);
         reg_wr(3'd2, 2 | hb);
         set_base(base, 1'(hb));
         reg_wr(3'd1, 4000);
         reg_wr(3'd3, 1);
         rdy_mode = 1;
         for (int p = 0; p < 25; p++) begin
            for (int t = 0; t < 50; t++) begin
               send_pkt(MP, 100 + p, ack);
               if (ack) break;
               wait_cyc(3);
            end
            if (ack) push_exp(100 + p, 0, MP);
         end
         fin = $urandom_range(0, MP - 1);
         for (int t = 0; t < 50; t++) begin
            send_pkt(fin, 200, ack);
            if (ack) break;
            wait_cyc(3);
         end
         push_exp(200, 0, fin);
         for (int t = 0; t < 500 && !irq_short; t++) @(negedge clk);
         chk("R8", "random irq_short", irq_short, 1);
         cmp_obs("R3");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule